// File: doc/BRIEF.md
# Multi-Cycle Load/Store Integer Core

This block is a small integer processor core with a multi-cycle control sequence. It fetches one 32-bit instruction word at a time from an instruction memory port and carries out one of five operations: load, store, add, increment, and a signed less-than compare-and-branch. Each memory address is the sum of two general registers, a base and an index. There are 64 general registers, and register 0 is an ordinary one. All data traffic uses a single data memory port. Peripherals sit in the same address space as memory, so the core has no separate I/O operations.

Both memory ports are synchronous, with one cycle of read latency, which suits block RAM. An add, increment, store or branch takes three cycles. A load takes five. When an instruction completes, the core samples a level-sensitive interrupt request. If the request is high, the next fetch comes from a fixed handler address, and a one-cycle acknowledge tells the device to drop its request. An unknown opcode halts the core at the offending instruction until the next reset.

Top module: `lsr_core`

## Requirements
- R1: While reset is high and after its release, the instruction address is 0, both data strobes are low, and the acknowledge and illegal flags are low. All 64 registers read as zero after reset.
- R2: An instruction word is decoded as follows. Bits [31:26] hold the opcode: 1 load, 2 store, 3 add, 4 increment, 5 branch. Bits [25:20] hold field A, bits [19:14] field B and bits [13:8] field C.
- R3: A load writes the data read at address RG[A]+RG[B] into RG[C], then moves to the next instruction.
- R4: A store writes RG[C] to address RG[A]+RG[B] with a write strobe lasting exactly one cycle. No other location changes.
- R5: An add writes RG[A]+RG[B] modulo 2^32 into RG[C].
- R6: An increment adds one modulo 2^32 to RG[A] in place.
- R7: The branch compares RG[A] and RG[B] as signed values. If RG[A] < RG[B], the instruction counter moves by the two's-complement offset in bits [13:0], which may point backward. Otherwise it moves by one.
- R8: Only loads raise the read strobe, once per load. Only stores raise the write strobe. The two strobes are never high together.
- R9: If the interrupt request is high when an instruction completes, the next fetch address is the handler address (default 64). The acknowledge is high for exactly that one cycle.
- R10: An opcode other than 1 to 5 sets the illegal flag. The instruction address then holds the offending location, and until reset there are no further fetches, data accesses or acknowledges, even if an interrupt is requested.
- R11: Register 0 can be written and read back like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction word address (the instruction counter) |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dmem_addr | output | XLEN | Data word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Write strobe |
| dmem_re | output | 1 | Read strobe |
| dmem_rdata | input | XLEN | Load data, one cycle after the read strobe |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_ack | output | 1 | Pulses in the cycle the handler fetch begins |
| illegal | output | 1 | Sticky unknown-opcode flag; the core is halted |

## Verification
Two cases are hardest to reach from the ports: a register value that never passes through a store, and an interrupt that arrives while the core is in a known place. The random programs handle the first. They mix all five operations over eight registers with forward branches, preload memory with full-range 32-bit values, and compare the final memory image and halt location against an instruction-level model in the bench. Interrupts are raised while the core spins on a one-instruction branch loop, so that the handler can record that it ran by storing a value.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam int FLD_W  = 6;
  localparam int OFF_W  = 14;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 6'd1,
    OP_STORE = 6'd2,
    OP_ADD   = 6'd3,
    OP_INCR  = 6'd4,
    OP_BLT   = 6'd5
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } state_e;
endpackage

// File: rtl/lsr_regfile.sv
module lsr_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_a,
  input  logic [IDX_W-1:0] ra_b,
  input  logic [IDX_W-1:0] ra_c,
  output logic [XLEN-1:0]  rd_a,
  output logic [XLEN-1:0]  rd_b,
  output logic [XLEN-1:0]  rd_c,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [XLEN-1:0]  wd
);
  logic [XLEN-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_c = regs[ra_c];
endmodule

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
#(
  parameter int PC_W = 16
)(
  input  logic [INSN_W-1:0] insn,
  output logic [FLD_W-1:0]  fa,
  output logic [FLD_W-1:0]  fb,
  output logic [FLD_W-1:0]  fc,
  output logic              is_load,
  output logic              is_store,
  output logic              is_add,
  output logic              is_incr,
  output logic              is_blt,
  output logic              is_bad,
  output logic [PC_W-1:0]   br_off
);
  logic signed [OFF_W-1:0] off_s;

  assign fa    = insn[31:26-FLD_W];
  assign fb    = insn[31-OPC_W-FLD_W -: FLD_W];
  assign fc    = insn[31-OPC_W-2*FLD_W -: FLD_W];
  assign off_s = insn[OFF_W-1:0];
  assign br_off = PC_W'(off_s);

  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    is_add   = 1'b0;
    is_incr  = 1'b0;
    is_blt   = 1'b0;
    is_bad   = 1'b0;
    case (insn[INSN_W-1 -: OPC_W])
      OP_LOAD:  is_load  = 1'b1;
      OP_STORE: is_store = 1'b1;
      OP_ADD:   is_add   = 1'b1;
      OP_INCR:  is_incr  = 1'b1;
      OP_BLT:   is_blt   = 1'b1;
      default:  is_bad   = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsr_exec.sv
module lsr_exec #(
  parameter int XLEN = 32,
  parameter int PC_W = 16
)(
  input  logic [XLEN-1:0] va,
  input  logic [XLEN-1:0] vb,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] br_off,
  input  logic            is_blt,
  output logic [XLEN-1:0] sum,
  output logic [XLEN-1:0] incr_v,
  output logic [PC_W-1:0] next_pc
);
  logic lt;

  assign sum    = va + vb;
  assign incr_v = va + XLEN'(1);
  assign lt     = $signed(va) < $signed(vb);
  assign next_pc = (is_blt && lt) ? pc + br_off : pc + PC_W'(1);
endmodule

// File: rtl/lsr_core.sv
module lsr_core
  import lsr_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          PC_W         = 16,
  parameter int          RF_DEPTH     = 64,
  parameter int unsigned HANDLER_ADDR = 64
)(
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [XLEN-1:0]   dmem_addr,
  output logic [XLEN-1:0]   dmem_wdata,
  output logic              dmem_we,
  output logic              dmem_re,
  input  logic [XLEN-1:0]   dmem_rdata,
  input  logic              irq,
  output logic              irq_ack,
  output logic              illegal
);
  localparam int IDX_W = $clog2(RF_DEPTH);
  localparam logic [PC_W-1:0] HANDLER_PC = PC_W'(HANDLER_ADDR);

  state_e            state;
  logic [PC_W-1:0]   pc;
  logic [INSN_W-1:0] ir;

  logic [FLD_W-1:0] fa, fb, fc;
  logic is_load, is_store, is_add, is_incr, is_blt, is_bad;
  logic [PC_W-1:0] br_off, next_pc;
  logic [XLEN-1:0] va, vb, vc, sum, incr_v;
  logic            rf_we;
  logic [IDX_W-1:0] rf_wa;
  logic [XLEN-1:0] rf_wd;

  lsr_decode #(.PC_W(PC_W)) u_dec (
    .insn(ir), .fa(fa), .fb(fb), .fc(fc),
    .is_load(is_load), .is_store(is_store), .is_add(is_add),
    .is_incr(is_incr), .is_blt(is_blt), .is_bad(is_bad), .br_off(br_off)
  );

  lsr_regfile #(.XLEN(XLEN), .DEPTH(RF_DEPTH)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(fa[IDX_W-1:0]), .ra_b(fb[IDX_W-1:0]), .ra_c(fc[IDX_W-1:0]),
    .rd_a(va), .rd_b(vb), .rd_c(vc),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  lsr_exec #(.XLEN(XLEN), .PC_W(PC_W)) u_ex (
    .va(va), .vb(vb), .pc(pc), .br_off(br_off), .is_blt(is_blt),
    .sum(sum), .incr_v(incr_v), .next_pc(next_pc)
  );

  assign imem_addr = pc;
  assign rf_we = (state == ST_WB) || (state == ST_EXEC && (is_add || is_incr));
  assign rf_wa = is_incr ? fa[IDX_W-1:0] : fc[IDX_W-1:0];
  assign rf_wd = (state == ST_WB) ? dmem_rdata : (is_incr ? incr_v : sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FETCH;
      pc         <= '0;
      ir         <= '0;
      dmem_addr  <= '0;
      dmem_wdata <= '0;
      dmem_we    <= 1'b0;
      dmem_re    <= 1'b0;
      irq_ack    <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      dmem_we <= 1'b0;
      dmem_re <= 1'b0;
      irq_ack <= 1'b0;
      case (state)
        ST_FETCH:  state <= ST_DECODE;
        ST_DECODE: begin
          ir    <= imem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (is_bad) begin
            illegal <= 1'b1;
            state   <= ST_HALT;
          end else if (is_load) begin
            dmem_addr <= sum;
            dmem_re   <= 1'b1;
            state     <= ST_MEM;
          end else begin
            if (is_store) begin
              dmem_addr  <= sum;
              dmem_wdata <= vc;
              dmem_we    <= 1'b1;
            end
            state <= ST_FETCH;
            if (irq) begin
              pc      <= HANDLER_PC;
              irq_ack <= 1'b1;
            end else begin
              pc <= next_pc;
            end
          end
        end
        ST_MEM: state <= ST_WB;
        ST_WB: begin
          state <= ST_FETCH;
          if (irq) begin
            pc      <= HANDLER_PC;
            irq_ack <= 1'b1;
          end else begin
            pc <= next_pc;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assert_reset_pc_R1: assert property (@(posedge clk)
    $past(rst) |-> (imem_addr == '0 && !dmem_we && !dmem_re && !illegal && !irq_ack));

  assert_decode_one_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({is_load, is_store, is_add, is_incr, is_blt, is_bad}) == 1);

  assert_store_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  assert_ack_target_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> imem_addr == HANDLER_PC);

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (illegal && $stable(imem_addr) && !dmem_we && !dmem_re && !irq_ack));
endmodule

// File: tb/tb_lsr_core.sv
`timescale 1ns/1ps
module tb_lsr_core;
  localparam int XLEN = 32;
  localparam int PC_W = 16;
  localparam int HND  = 64;
  localparam int MW   = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_rdata;
  logic [XLEN-1:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we, dmem_re, irq, irq_ack, illegal;

  lsr_core #(.XLEN(XLEN), .PC_W(PC_W), .RF_DEPTH(64), .HANDLER_ADDR(HND)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .irq(irq),
    .irq_ack(irq_ack), .illegal(illegal)
  );

  logic [31:0] imem [MW];
  logic [31:0] dmem [MW];
  logic [31:0] mreg [64];
  logic [31:0] mmem [MW];
  logic [15:0] mhalt;

  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[7:0]];
    dmem_rdata <= dmem[dmem_addr[7:0]];
    if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
  end

  int total = 0;
  int bad = 0;
  bit done = 0;
  int we_cnt, re_cnt, both_cnt;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [5:0] op, logic [5:0] a, logic [5:0] b, logic [5:0] c);
    return {op, a, b, c, 8'h00};
  endfunction

  function automatic logic [31:0] enc_br(logic [5:0] a, logic [5:0] b, logic [13:0] off);
    return {6'd5, a, b, off};
  endfunction

  task automatic clear_mems();
    for (int i = 0; i < MW; i++) begin
      imem[i] = '0;
      dmem[i] = '0;
    end
  endtask

  // Instruction-level model built from the requirements
  task automatic model_run();
    logic [15:0] pc;
    pc = '0;
    for (int i = 0; i < 64; i++) mreg[i] = '0;
    for (int i = 0; i < MW; i++) mmem[i] = dmem[i];
    mhalt = 16'hFFFF;
    for (int s = 0; s < 4000; s++) begin
      logic [31:0] w, ad;
      logic [5:0] a, b, c;
      logic signed [13:0] off;
      w = imem[pc[7:0]];
      a = w[25:20]; b = w[19:14]; c = w[13:8]; off = w[13:0];
      ad = mreg[a] + mreg[b];
      case (w[31:26])
        6'd1: begin mreg[c] = mmem[ad[7:0]]; pc = pc + 16'd1; end
        6'd2: begin mmem[ad[7:0]] = mreg[c]; pc = pc + 16'd1; end
        6'd3: begin mreg[c] = mreg[a] + mreg[b]; pc = pc + 16'd1; end
        6'd4: begin mreg[a] = mreg[a] + 32'd1; pc = pc + 16'd1; end
        6'd5: begin
          if ($signed(mreg[a]) < $signed(mreg[b])) pc = pc + 16'($signed(off));
          else pc = pc + 16'd1;
        end
        default: begin mhalt = pc; return; end
      endcase
    end
  endtask

  task automatic start_dut();
    rst = 1'b1;
    irq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset imem_addr", 32'(imem_addr), 32'h0);
    chk("R1", "reset strobes", {30'h0, dmem_we, dmem_re}, 32'h0);
    chk("R1", "reset flags", {30'h0, illegal, irq_ack}, 32'h0);
    rst = 1'b0;
    we_cnt = 0; re_cnt = 0; both_cnt = 0;
  endtask

  task automatic wait_halt(int limit);
    int n;
    n = 0;
    while (!illegal && n < limit) begin
      @(negedge clk);
      if (dmem_we) we_cnt++;
      if (dmem_re) re_cnt++;
      if (dmem_we && dmem_re) both_cnt++;
      n++;
    end
    chk("R10", "halted within limit", {31'h0, illegal}, 32'h1);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare_model(string req);
    chk(req, "halt location", 32'(imem_addr), 32'(mhalt));
    for (int i = 0; i < MW; i++) chk(req, "memory word", dmem[i], mmem[i]);
    chk("R8", "both strobes high", 32'(both_cnt), 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd9173);
    irq = 1'b0;

    // Directed: load, add/incr wrap, store, register 0
    clear_mems();
    dmem[0] = 32'hFFFF_FFFF; dmem[1] = 32'd7; dmem[11] = 32'h0000_ABCD;
    imem[0]  = enc(1, 2, 2, 5);
    imem[1]  = enc(4, 3, 0, 0);
    imem[2]  = enc(1, 2, 3, 6);
    imem[3]  = enc(3, 5, 6, 7);
    imem[4]  = enc(4, 5, 0, 0);
    imem[5]  = enc(4, 3, 0, 0);
    imem[6]  = enc(2, 2, 3, 7);
    imem[7]  = enc(4, 3, 0, 0);
    imem[8]  = enc(2, 2, 3, 5);
    imem[9]  = enc(4, 0, 0, 0);
    imem[10] = enc(4, 3, 0, 0);
    imem[11] = enc(2, 2, 3, 0);
    imem[12] = enc(1, 3, 6, 8);
    imem[13] = enc(4, 3, 0, 0);
    imem[14] = enc(2, 2, 3, 8);
    model_run();
    start_dut();
    wait_halt(400);
    chk("R5", "add wraps", dmem[2], 32'd6);
    chk("R6", "incr wraps", dmem[3], 32'd0);
    chk("R11", "register 0 written", dmem[4], 32'd1);
    chk("R3", "load base+index", dmem[5], 32'h0000_ABCD);
    chk("R4", "untouched word", dmem[0], 32'hFFFF_FFFF);
    chk("R4", "store strobe count", 32'(we_cnt), 32'd4);
    chk("R8", "load strobe count", 32'(re_cnt), 32'd3);
    chk("R10", "halt pc", 32'(imem_addr), 32'd15);
    compare_model("R2");

    // Directed: branch signed, taken, not taken, backward loop
    clear_mems();
    dmem[0] = 32'h8000_0000; dmem[1] = 32'd5;
    imem[0]  = enc(1, 2, 2, 1);
    imem[1]  = enc_br(1, 2, 14'd2);
    imem[2]  = enc(4, 10, 0, 0);
    imem[3]  = enc_br(2, 1, 14'd5);
    imem[4]  = enc(4, 11, 0, 0);
    imem[5]  = enc(4, 3, 0, 0);
    imem[6]  = enc(1, 2, 3, 14);
    imem[7]  = enc(4, 12, 0, 0);
    imem[8]  = enc_br(12, 14, 14'h3FFF);
    imem[9]  = enc(4, 3, 0, 0);
    imem[10] = enc(2, 2, 3, 12);
    imem[11] = enc(4, 3, 0, 0);
    imem[12] = enc(2, 2, 3, 10);
    imem[13] = enc(4, 3, 0, 0);
    imem[14] = enc(2, 2, 3, 11);
    model_run();
    start_dut();
    wait_halt(600);
    chk("R7", "backward loop count", dmem[2], 32'd5);
    chk("R7", "taken skips", dmem[3], 32'd0);
    chk("R7", "not taken falls through", dmem[4], 32'd1);
    compare_model("R7");

    // Directed: interrupt while spinning
    clear_mems();
    imem[0] = enc(4, 1, 0, 0);
    imem[1] = enc_br(0, 1, 14'd0);
    imem[HND]   = enc(4, 2, 0, 0);
    imem[HND+1] = enc(4, 2, 0, 0);
    imem[HND+2] = enc(2, 0, 1, 2);
    start_dut();
    begin
      int n, early;
      n = 0; early = 0;
      repeat (30) begin
        @(negedge clk);
        if (irq_ack) early++;
      end
      chk("R9", "no ack without request", 32'(early), 32'd0);
      irq = 1'b1;
      while (!irq_ack && n < 50) begin @(negedge clk); n++; end
      chk("R9", "ack seen", {31'h0, irq_ack}, 32'h1);
      chk("R9", "handler address", 32'(imem_addr), 32'(HND));
      irq = 1'b0;
      @(negedge clk);
      chk("R9", "ack one cycle", {31'h0, irq_ack}, 32'h0);
    end
    wait_halt(200);
    chk("R9", "handler ran", dmem[1], 32'd2);
    chk("R10", "halt after handler", 32'(imem_addr), 32'(HND + 3));

    // Directed: unknown opcode mid-program, request ignored while halted
    clear_mems();
    dmem[1] = 32'hDEAD;
    imem[0] = enc(4, 3, 0, 0);
    imem[1] = enc(6'h3F, 0, 0, 0);
    imem[2] = enc(2, 0, 3, 3);
    start_dut();
    wait_halt(100);
    chk("R10", "halt at bad opcode", 32'(imem_addr), 32'd1);
    irq = 1'b1;
    begin
      int acts;
      acts = 0;
      repeat (20) begin
        @(negedge clk);
        if (dmem_we || dmem_re || irq_ack) acts++;
      end
      chk("R10", "activity while halted", 32'(acts), 32'd0);
    end
    irq = 1'b0;
    chk("R10", "later store skipped", dmem[1], 32'hDEAD);
    chk("R10", "address still held", 32'(imem_addr), 32'd1);

    // Random programs against the model
    for (int round = 0; round < 25; round++) begin
      clear_mems();
      for (int i = 0; i < MW; i++) dmem[i] = $urandom();
      for (int i = 0; i < 48; i++) begin
        logic [5:0] a, b, c;
        a = 6'($urandom_range(0, 7));
        b = 6'($urandom_range(0, 7));
        c = 6'($urandom_range(0, 7));
        case ($urandom_range(0, 4))
          0: imem[i] = enc(1, a, b, c);
          1: imem[i] = enc(2, a, b, c);
          2: imem[i] = enc(3, a, b, c);
          3: imem[i] = enc(4, a, 0, 0);
          default: imem[i] = enc_br(a, b, 14'($urandom_range(1, 3)));
        endcase
      end
      model_run();
      start_dut();
      wait_halt(2000);
      compare_model("R3");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule